// File: doc/BRIEF.md
# Configurable-Mode SPI Master Engine

This block is a full-duplex SPI master for one slave device. A single start strobe sends one frame out on MOSI, most significant bit first. In the same frame it shifts a word of the same length in from MISO. When the frame is complete, a one-cycle done pulse presents the received word. The frame length is 8 or 16 bits. All four combinations of clock idle level and sampling phase are available. SCK runs at a programmable fraction of the system clock.

The control word is written through a single write strobe. The clock phase can be given in either of two ways:

- directly, as the phase bit;
- as an inverted "edge" bit, in which the bit names the transition on which MOSI changes.

An extra option moves the MISO capture point from mid-bit to the close of the bit time. MISO passes through a synchronizer, and the sample strobe is delayed by the same number of cycles, so each captured bit is the line value at the exact SCK event. All mode fields are frozen while the enable bit is set.

Top module: `spi_mode_master`

## Requirements
- R1: While cs_n is high, sck rests at the programmed idle level: low for polarity 0, high for polarity 1. After reset, cs_n=1, sck=0, busy=0 and done=0.
- R2: With phase 0, MISO is captured on the odd-numbered SCK edges (1, 3, …). The first MOSI bit is present from the moment cs_n falls. MOSI changes only on even-numbered edges.
- R3: With phase 1, MOSI changes on the odd-numbered edges, starting with edge 1. MISO is captured on the even-numbered edges (2, 4, …).
- R4: With cfg_alt=1, cfg_phase is read as an edge bit. A value of 1 (MOSI changes on the active-to-idle transition) selects phase 0. A value of 0 (MOSI changes on the idle-to-active transition) selects phase 1. With cfg_alt=0, cfg_phase is the phase itself.
- R5: cfg_wide=1 selects 16-bit frames and cfg_wide=0 selects 8-bit frames; a frame of N bits makes exactly 2N SCK edges. MOSI carries tx_data most significant bit first. An 8-bit frame sends tx_data[7:0], and rx_data[15:8] reads zero.
- R6: With cfg_late=1, each MISO bit is captured one half SCK period after its normal capture edge. The last bit with phase 1 is captured at the moment cs_n rises.
- R7: cfg_pol, cfg_phase, cfg_alt, cfg_wide, cfg_late and cfg_div take effect on a write only while the stored enable bit is 0. While it is 1 they are ignored; cfg_en itself is always written.
- R8: The time from cs_n falling to the first SCK edge, the time between successive edges, and the time from the last edge to cs_n rising are each cfg_div+1 system clocks.
- R9: A start strobe is accepted only while the engine is enabled and not busy. A strobe that arrives while busy or disabled has no effect.
- R10: busy rises on the clock after an accepted start and falls when done is raised. done is one clock wide, arrives two clocks after cs_n rises, and comes with the complete received word on rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_en | input | 1 | Enable bit value to write |
| cfg_pol | input | 1 | SCK idle level |
| cfg_phase | input | 1 | Phase bit, or inverted edge bit when cfg_alt=1 |
| cfg_alt | input | 1 | Selects the edge-bit encoding for cfg_phase |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_late | input | 1 | Capture MISO at the end of the bit time |
| cfg_div | input | 8 | SCK half period minus one, in system clocks |
| start | input | 1 | Begin a frame |
| tx_data | input | 16 | Word to send, captured with start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rx_data | output | 16 | Received word, valid with done |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in, asynchronous |
| cs_n | output | 1 | Active-low slave select |

## Verification
The done pulse and a new start strobe can land in the same clock. The engine returns to idle on the edge that raises done, so a start held during the done cycle must be accepted at once. The bench provokes this by raising start at the falling clock edge where it first sees done. It then judges that busy is set one clock later and that the next frame has correct edge spacing, MOSI word and MISO word. A start pulsed in the middle of a running frame is also checked: the frame must finish with the first word, and no extra done may appear.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DIV_W        = 8;
  localparam int FRAME_MAX    = 16;
  localparam int FRAME_NARROW = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } spim_state_e;

  typedef struct packed {
    logic             pol;
    logic             pha;
    logic             wide;
    logic             late;
    logic [DIV_W-1:0] div;
  } spim_cfg_t;
endpackage

// File: rtl/spim_cfg_reg.sv
module spim_cfg_reg
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             en_in,
  input  logic             pol_in,
  input  logic             phase_in,
  input  logic             alt_in,
  input  logic             wide_in,
  input  logic             late_in,
  input  logic [DIV_W-1:0] div_in,
  output logic             en,
  output spim_cfg_t        cfg
);
  logic      en_d;
  spim_cfg_t cfg_d;

  always_comb begin
    en_d  = en;
    cfg_d = cfg;
    if (wr) begin
      en_d = en_in;
      if (!en) begin
        cfg_d.pol  = pol_in;
        cfg_d.pha  = alt_in ? ~phase_in : phase_in;
        cfg_d.wide = wide_in;
        cfg_d.late = late_in;
        cfg_d.div  = div_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cfg <= '0;
    end else if (wr) begin
      en  <= en_d;
      cfg <= cfg_d;
    end
  end

  // mode fields are frozen while enabled
  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cfg));
endmodule

// File: rtl/spim_tick_gen.sv
module spim_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, cnt_d;

  assign tick = run && (cnt == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spim_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_en,
  input  logic                 cfg_pol,
  input  logic                 cfg_phase,
  input  logic                 cfg_alt,
  input  logic                 cfg_wide,
  input  logic                 cfg_late,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] tx_data,
  output logic                 busy,
  output logic                 done,
  output logic [FRAME_MAX-1:0] rx_data,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 cs_n
);
  localparam int TCNT_W = $clog2(2 * FRAME_MAX + 2);
  localparam int DR_W   = (SYNC_STAGES > 2) ? $clog2(SYNC_STAGES) : 1;
  localparam int PAD    = FRAME_MAX - FRAME_NARROW;

  logic      en;
  spim_cfg_t cfg;
  logic      tick, miso_s;

  spim_state_e            state, state_d;
  logic [TCNT_W-1:0]      tcnt, tcnt_d, t_next, n_bits, last_edge, offs;
  logic                   tgl, tgl_d, cs_q, cs_d, mosi_q, mosi_d, done_q, done_d;
  logic [FRAME_MAX-1:0]   txsr, txsr_d, rxsr, rxsr_d, aligned;
  logic [SYNC_STAGES-1:0] spl, spl_d;
  logic [DR_W-1:0]        dr, dr_d;
  logic                   accept, sample_hit, launch_hit, sample_now;

  spim_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we), .en_in(cfg_en), .pol_in(cfg_pol),
    .phase_in(cfg_phase), .alt_in(cfg_alt), .wide_in(cfg_wide),
    .late_in(cfg_late), .div_in(cfg_div), .en(en), .cfg(cfg)
  );

  spim_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .div(cfg.div), .tick(tick)
  );

  spim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(miso), .q(miso_s)
  );

  // edge numbering: tick t (1-based) toggles SCK for t <= 2N, releases cs at 2N+1
  always_comb begin
    n_bits     = cfg.wide ? TCNT_W'(FRAME_MAX) : TCNT_W'(FRAME_NARROW);
    last_edge  = n_bits << 1;
    t_next     = tcnt + TCNT_W'(1);
    offs       = TCNT_W'(cfg.pha) + TCNT_W'(cfg.late);
    sample_hit = (t_next >= TCNT_W'(1) + offs) &&
                 (t_next <= last_edge - TCNT_W'(1) + offs) &&
                 (t_next[0] ^ cfg.pha ^ cfg.late);
    launch_hit = (t_next < last_edge) && (cfg.pha ? t_next[0] : !t_next[0]);
    aligned    = cfg.wide ? tx_data : (tx_data << PAD);
  end

  assign accept     = (state == ST_IDLE) && start && en;
  assign sample_now = (state == ST_RUN) && tick && sample_hit;

  always_comb begin
    state_d = state;
    tcnt_d  = tcnt;
    tgl_d   = tgl;
    cs_d    = cs_q;
    mosi_d  = mosi_q;
    txsr_d  = txsr;
    rxsr_d  = rxsr;
    dr_d    = dr;
    done_d  = 1'b0;
    // sample strobe delayed to line up with the synchronizer output
    spl_d   = {spl[SYNC_STAGES-2:0], sample_now};
    if (spl[SYNC_STAGES-1]) rxsr_d = {rxsr[FRAME_MAX-2:0], miso_s};
    case (state)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          tcnt_d  = '0;
          tgl_d   = 1'b0;
          cs_d    = 1'b0;
          rxsr_d  = '0;
          txsr_d  = aligned;
          if (!cfg.pha) begin
            mosi_d = aligned[FRAME_MAX-1];
            txsr_d = aligned << 1;
          end
        end
      end
      ST_RUN: begin
        if (tick) begin
          tcnt_d = t_next;
          if (t_next <= last_edge) tgl_d = ~tgl;
          if (launch_hit) begin
            mosi_d = txsr[FRAME_MAX-1];
            txsr_d = txsr << 1;
          end
          if (t_next == last_edge + TCNT_W'(1)) begin
            cs_d    = 1'b1;
            state_d = ST_DRAIN;
            dr_d    = '0;
          end
        end
      end
      ST_DRAIN: begin
        if (dr == DR_W'(SYNC_STAGES - 1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dr_d = dr + DR_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tcnt   <= '0;
      tgl    <= 1'b0;
      cs_q   <= 1'b1;
      mosi_q <= 1'b0;
      txsr   <= '0;
      rxsr   <= '0;
      spl    <= '0;
      dr     <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= state_d;
      tcnt   <= tcnt_d;
      tgl    <= tgl_d;
      cs_q   <= cs_d;
      mosi_q <= mosi_d;
      txsr   <= txsr_d;
      rxsr   <= rxsr_d;
      spl    <= spl_d;
      dr     <= dr_d;
      done_q <= done_d;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign rx_data = rxsr;
  assign cs_n    = cs_q;
  assign mosi    = mosi_q;
  assign sck     = cfg.pol ^ tgl;

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cfg.pol));

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && en));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_select_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

// File: tb/spi_mode_master_tb.sv
module spi_mode_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_en, cfg_pol, cfg_phase, cfg_alt, cfg_wide, cfg_late;
  logic [7:0]  cfg_div;
  logic        start;
  logic [15:0] tx_data;
  logic        busy, done, sck, mosi, miso, cs_n;
  logic [15:0] rx_data;

  int checks = 0;
  int failures = 0;

  // bench's own view of the active mode, derived from the requirements
  logic       cur_en = 1'b0;
  logic       e_pol = 1'b0, e_pha = 1'b0, e_wide = 1'b0, e_late = 1'b0;
  logic [7:0] e_div = 8'd0;
  string      test_tag = "";

  logic [15:0] exp_tx[$];
  logic [15:0] exp_rx[$];
  int launched = 0;
  int done_cnt = 0;

  always #10 clk = ~clk;

  spi_mode_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_pol(cfg_pol), .cfg_phase(cfg_phase), .cfg_alt(cfg_alt),
    .cfg_wide(cfg_wide), .cfg_late(cfg_late), .cfg_div(cfg_div),
    .start(start), .tx_data(tx_data), .busy(busy), .done(done),
    .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return e_wide ? 16 : 8;
  endfunction

  // standard capture edge for the current phase (R2, R3)
  function automatic bit std_edge(input int ev);
    if (ev < 1 || ev > 2 * nbits()) return 1'b0;
    return e_pha ? (ev % 2 == 0) : (ev % 2 == 1);
  endfunction

  // MISO capture event, shifted half a bit when late (R6)
  function automatic bit rx_event(input int ev);
    return e_late ? std_edge(ev - 1) : std_edge(ev);
  endfunction

  // ---------------- monitor / scoreboard ----------------
  logic        prev_sck, prev_cs, prev_done;
  int          ev, cyc, since_cs;
  logic [15:0] mw, rw, lf;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck = sck; prev_cs = 1'b1; prev_done = 1'b0;
      ev = 0; cyc = 0; since_cs = 100; mw = 0; rw = 0;
      lf = 16'hACE1;
      miso = 1'b0;
    end else begin
      cyc++;
      since_cs++;
      if (prev_cs && !cs_n) begin
        ev = 0; cyc = 0; mw = 0; rw = 0;
      end else if (!cs_n && (sck !== prev_sck)) begin
        ev++;
        chk(cyc == int'(e_div) + 1, "R8 edge spacing", cyc, e_div + 1);
        cyc = 0;
        if (std_edge(ev)) mw = {mw[14:0], mosi};
        if (rx_event(ev)) rw = {rw[14:0], miso};
      end else if (cs_n && !prev_cs) begin
        ev++;
        chk(cyc == int'(e_div) + 1, "R8 cs release delay", cyc, e_div + 1);
        if (rx_event(ev)) rw = {rw[14:0], miso};
        chk(ev == 2 * nbits() + 1, "R5 edges per frame", ev - 1, 2 * nbits());
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R9 unexpected frame", 1, 0);
        end else begin
          logic [15:0] t;
          t = exp_tx.pop_front();
          if (!e_wide) t = {8'h00, t[7:0]};
          chk(mw == t, {"R5 mosi word msb first ", test_tag}, mw, t);
        end
        exp_rx.push_back(rw);
        since_cs = 0;
      end
      if (done) begin
        done_cnt++;
        chk(since_cs == 2, "R10 done two clocks after cs_n rise", since_cs, 2);
        chk(!prev_done, "R10 done one clock wide", prev_done, 0);
        if (exp_rx.size() == 0) begin
          chk(1'b0, "R10 done without frame", 1, 0);
        end else begin
          logic [15:0] r;
          r = exp_rx.pop_front();
          chk(rx_data == r,
              {e_late ? "R6" : (e_pha ? "R3" : "R2"), " rx word ", test_tag},
              rx_data, r);
        end
      end
      prev_sck = sck; prev_cs = cs_n; prev_done = done;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      miso = lf[0];
    end
  end

  // ---------------- driver tasks ----------------
  task automatic cfg(input logic en, pol, ph, alt, wide, late, input logic [7:0] div);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_pol = pol; cfg_phase = ph; cfg_alt = alt;
    cfg_wide = wide; cfg_late = late; cfg_div = div;
    if (!cur_en) begin
      e_pol = pol; e_pha = alt ? ~ph : ph; e_wide = wide; e_late = late; e_div = div;
    end
    cur_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // caller is at a falling edge
  task automatic launch(input logic [15:0] d);
    start = 1'b1; tx_data = d;
    exp_tx.push_back(d);
    launched++;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] d);
    @(negedge clk);
    launch(d);
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_en = 0; cfg_pol = 0; cfg_phase = 0; cfg_alt = 0;
    cfg_wide = 0; cfg_late = 0; cfg_div = 0; start = 0; tx_data = 0; miso = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(sck === 1'b0, "R1 reset sck", sck, 0);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    chk(done === 1'b0, "R1 reset done", done, 0);

    // R9: start while disabled
    start = 1'b1; tx_data = 16'h00FF;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && cs_n === 1'b1, "R9 start while disabled", busy, 0);

    // mode 0, 8-bit
    test_tag = "mode0";
    cfg(1, 0, 0, 0, 0, 0, 8'd1);
    xfer(16'h00A5);
    xfer(16'h123C);

    // R7: mode write while enabled is ignored
    cfg(1, 1, 1, 0, 1, 1, 8'd3);
    @(negedge clk);
    chk(sck === 1'b0, "R7 polarity write ignored while enabled", sck, 0);
    test_tag = "R7 locked";
    xfer(16'h005A);

    // mode 2, 16-bit; R1 idle high
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(0, 1, 0, 0, 1, 0, 8'd2);
    @(negedge clk);
    chk(sck === 1'b1, "R1 idle high with polarity 1", sck, 1);
    cfg(1, 1, 0, 0, 1, 0, 8'd2);
    test_tag = "mode2";
    xfer(16'hC3A5);
    chk(sck === 1'b1, "R1 idle high after frame", sck, 1);

    // mode 1, 16-bit
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 0, 1, 0, 1, 0, 8'd2);
    test_tag = "mode1";
    xfer(16'h1234);
    xfer(16'hFEDC);

    // mode 3, 8-bit, fastest clock
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 1, 1, 0, 0, 0, 8'd0);
    test_tag = "mode3";
    xfer(16'h0081);

    // R4: edge-bit encoding
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 0, 1, 1, 0, 0, 8'd1);
    test_tag = "R4 edge=1";
    xfer(16'h0096);
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 1, 0, 1, 1, 0, 8'd1);
    test_tag = "R4 edge=0";
    xfer(16'h6E2B);

    // R6: sample at end of bit
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 0, 0, 0, 1, 1, 8'd3);
    test_tag = "late pha0";
    xfer(16'hBEEF);
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 1, 1, 0, 0, 1, 8'd2);
    test_tag = "late pha1";
    xfer(16'h004D);
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 0, 1, 0, 1, 1, 8'd0);
    test_tag = "late pha1 div0";
    xfer(16'h9C71);

    // R9: start while busy is ignored
    cfg(0, 0, 0, 0, 0, 0, 8'd0);
    cfg(1, 0, 0, 0, 1, 0, 8'd1);
    test_tag = "R9 busy start";
    @(negedge clk);
    launch(16'hAAAA);
    repeat (6) @(negedge clk);
    start = 1'b1; tx_data = 16'h5555;
    @(negedge clk); start = 1'b0; tx_data = 16'h0000;
    wait_done();
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R9 no frame from ignored start", busy, 0);

    // done and start in the same cycle
    test_tag = "R10 back-to-back";
    xfer(16'h0F0F);
    launch(16'hF00D);
    wait_done();
    repeat (4) @(negedge clk);

    chk(done_cnt == launched, "R9 done count", done_cnt, launched);
    chk(exp_tx.size() == 0, "R9 pending frames", exp_tx.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule